// File: doc/BRIEF.md
# PWM Low-Side Convert-Start Delay Generator

This block watches the active low-side phase of a PWM output and, a programmable number of clocks after that phase begins, issues a single-cycle convert-start pulse to an ADC. Software sets the delay and turns the function on or off through one 8-bit control register. The register is written and read back over a simple single-register bus port.

The low-side input is asynchronous. It passes through a two-flop synchroniser, and a rising edge is detected on the synchronised level. That edge loads a 6-bit down-counter with the programmed delay. If the low-side phase ends before the count expires, or if the function is switched off during the count, the count is dropped and no pulse is issued for that phase. When the count expires, a one-cycle internal trigger is raised. The trigger is registered once more before it leaves the block.

Control register layout: bit 7 is the enable. Bits 3:0 are the delay code, giving a delay D = 4 × (code + 1) clocks, from 4 up to 64.

Top module: `pwm_conv_start_delay`

## Requirements
- R1: After reset the control register reads 0x00 and `conv_start` is low.
- R2: A write with `bus_we` high stores bit 7 (enable) and bits 3:0 (delay code). Both read back unchanged on `bus_rdata` from the next cycle.
- R3: Bits 6:4 of `bus_rdata` always read zero, and writes to them have no effect.
- R4: With the enable set, take P1 as the first rising clock edge at which `pwm_ls` is high. `conv_start` is then high for exactly one cycle, after edge P(D+4), where D = 4 × (code + 1). For example, code 0 gives edge P8 and code 15 gives edge P68.
- R5: With the enable clear, a low-side phase produces no pulse. Clearing the enable while a count is in progress cancels that count.
- R6: If `pwm_ls` is high at edges P1..PW only and W ≤ D, no pulse is issued for that phase. If W = D + 1, the pulse is issued as in R4.
- R7: A new delay code written while a count runs does not change that count. It applies from the next rising edge of `pwm_ls`.
- R8: A single low-side phase yields at most one pulse, however long it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Control register write strobe |
| bus_wdata | input | 8 | Control register write data |
| bus_rdata | output | 8 | Control register read-back |
| pwm_ls | input | 1 | Active low-side PWM level, asynchronous |
| conv_start | output | 1 | One-cycle ADC convert-start pulse |

## Verification
On every cycle, the assertions check four things:
- the internal trigger is one cycle wide;
- the trigger never fires unless the synchronised level was high;
- a count in progress is dropped once the level falls or the enable is cleared;
- the output stage follows the trigger by exactly one cycle.

Only the bench scenarios can show:
- the exact D + 4 edge latency across several codes;
- the W = D versus W = D + 1 width boundary;
- that a delay written during a count is deferred to the next phase;
- the read-back masking of the reserved bits.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int CTRL_W  = 8;
  localparam int CODE_W  = 4;
  localparam int STEP    = 4;
  localparam int EN_BIT  = 7;
  localparam int CNT_W   = $clog2(STEP * (2 ** CODE_W));

  typedef struct packed {
    logic              en;
    logic [CODE_W-1:0] code;
  } ctrl_t;
endpackage

// File: rtl/cs_ctrl_reg.sv
module cs_ctrl_reg
  import cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              en_in,
  input  logic [CODE_W-1:0] code_in,
  output ctrl_t             ctrl_o,
  output logic [CTRL_W-1:0] rdata_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (we) begin
      ctrl_q.en   <= en_in;
      ctrl_q.code <= code_in;
    end
  end

  always_comb begin
    rdata_o                = '0;
    rdata_o[EN_BIT]        = ctrl_q.en;
    rdata_o[CODE_W-1:0]    = ctrl_q.code;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/cs_edge_sync.sv
module cs_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= async_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cs_delay_timer.sv
module cs_delay_timer
  import cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              rise_i,
  input  logic              level_i,
  output logic              trig_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic [CNT_W:0]   load_wide;

  // Step count minus one, so a zero count marks expiry
  assign load_wide = (CNT_W+1)'(STEP) * ((CNT_W+1)'(code_i) + 1'b1) - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      trig_o   <= 1'b0;
    end else begin
      trig_o <= 1'b0;
      if (!en_i) begin
        active_q <= 1'b0;
      end else if (rise_i) begin
        active_q <= 1'b1;
        cnt_q    <= load_wide[CNT_W-1:0];
      end else if (active_q) begin
        if (!level_i) begin
          active_q <= 1'b0;
        end else if (cnt_q == '0) begin
          active_q <= 1'b0;
          trig_o   <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assert_trig_single_R8: assert property (@(posedge clk) disable iff (rst)
    trig_o |=> !trig_o);

  assert_trig_needs_level_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(trig_o) |-> $past(level_i));

  assert_cancel_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
    (active_q && !level_i && !rise_i) |=> (!active_q && !trig_o));

  assert_disable_abort_R5: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!active_q && !trig_o));
endmodule

// File: rtl/pwm_conv_start_delay.sv
module pwm_conv_start_delay
  import cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [CTRL_W-1:0] bus_wdata,
  output logic [CTRL_W-1:0] bus_rdata,
  input  logic              pwm_ls,
  output logic              conv_start
);
  ctrl_t ctrl;
  logic  ls_level;
  logic  ls_rise;
  logic  trig;
  logic  rsvd_unused;

  assign rsvd_unused = ^bus_wdata[EN_BIT-1:CODE_W];

  cs_ctrl_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .we      (bus_we),
    .en_in   (bus_wdata[EN_BIT]),
    .code_in (bus_wdata[CODE_W-1:0]),
    .ctrl_o  (ctrl),
    .rdata_o (bus_rdata)
  );

  cs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pwm_ls),
    .level_o (ls_level),
    .rise_o  (ls_rise)
  );

  cs_delay_timer u_timer (
    .clk     (clk),
    .rst     (rst),
    .en_i    (ctrl.en),
    .code_i  (ctrl.code),
    .rise_i  (ls_rise),
    .level_i (ls_level),
    .trig_o  (trig)
  );

  // Extra stage toward the ADC side
  always_ff @(posedge clk) begin
    if (rst) conv_start <= 1'b0;
    else     conv_start <= trig;
  end

  assert_out_follows_trig_R4: assert property (@(posedge clk) disable iff (rst)
    trig |=> conv_start);

  assert_out_only_from_trig_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_start) |-> $past(trig));
endmodule

// File: tb/pwm_conv_start_delay_tb.sv
module pwm_conv_start_delay_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       pwm_ls = 1'b0;
  logic       conv_start;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwm_conv_start_delay u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwm_ls(pwm_ls), .conv_start(conv_start)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  // Raise pwm_ls, keep it high for width edges, optionally write at act_cyc.
  // Returns first pulse edge index (0 if none) and pulse count.
  task automatic run_phase(input int width, input int act_cyc, input logic [7:0] act_d,
                           output int lat, output int npulse);
    lat = 0; npulse = 0;
    @(negedge clk);
    pwm_ls = 1'b1;
    for (int i = 1; i <= width + 80; i++) begin
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
      if (conv_start) begin
        npulse++;
        if (lat == 0) lat = i;
      end
      if (i == width) pwm_ls = 1'b0;
      if (i == act_cyc) begin bus_we = 1'b1; bus_wdata = act_d; end
    end
    bus_we = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 rdata", int'(bus_rdata), 0);
    check("R1 conv_start", int'(conv_start), 0);
  endtask

  task automatic t_regs;
    reg_write(8'hFA);
    check("R2 readback", int'(bus_rdata), 8'h8A);
    check("R3 reserved bits", int'(bus_rdata[6:4]), 0);
    reg_write(8'h75);
    check("R3 reserved ignored", int'(bus_rdata), 8'h05);
  endtask

  task automatic t_delay(input int code);
    int lat, n;
    reg_write(8'h80 | 8'(code));
    run_phase(120, 0, 8'h00, lat, n);
    check($sformatf("R4 latency code %0d", code), lat, 4 * (code + 1) + 4);
    check($sformatf("R8 one pulse code %0d", code), n, 1);
  endtask

  task automatic t_disabled;
    int lat, n;
    reg_write(8'h03);
    run_phase(40, 0, 8'h00, lat, n);
    check("R5 disabled no pulse", n, 0);
    reg_write(8'h8F);
    run_phase(100, 10, 8'h0F, lat, n);
    check("R5 abort on disable", n, 0);
  endtask

  task automatic t_width;
    int lat, n;
    reg_write(8'h82);              // D = 12
    run_phase(12, 0, 8'h00, lat, n);
    check("R6 width D no pulse", n, 0);
    run_phase(13, 0, 8'h00, lat, n);
    check("R6 width D+1 pulse", n, 1);
    check("R6 width D+1 latency", lat, 16);
    run_phase(3, 0, 8'h00, lat, n);
    check("R6 short phase", n, 0);
  endtask

  task automatic t_change;
    int lat, n;
    reg_write(8'h8F);              // D = 64
    run_phase(100, 5, 8'h80, lat, n);
    check("R7 old delay kept", lat, 68);
    check("R7 single pulse", n, 1);
    run_phase(100, 0, 8'h00, lat, n);
    check("R7 new delay applied", lat, 8);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_delay(0);
    t_delay(5);
    t_delay(15);
    t_disabled();
    t_width();
    t_change();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule